// File: doc/BRIEF.md
# GF(2^8) Power-Chain Inverter

This block returns the multiplicative inverse of one element of the field GF(2^8) in a single pass. Elements use the polynomial basis over the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D). The inverse is computed as the input raised to the power 254, with no lookup table and no iterative Euclidean unit.

The exponent is assembled as a^224 · a^24 · a^6. The cube a^3 is formed once as a^2·a. Squaring it gives a^6. A further multiply by a gives a^7, and repeated squaring and fourth-power stages lift a^7 to a^224 and a^6 to a^24. Squaring and raising to the fourth power are linear over GF(2), so each is a fixed XOR network, which costs much less than a general multiplier. Four general multipliers combine the partial powers.

A parameter selects between two output modes. In the first, the result is purely combinational. In the second, the result is held in a single output register that shortens the critical path, and the valid flag is delayed to match.

Top module: `gf8_inverter`

## Requirements
- R1: For every nonzero input a, the product a · out_inv in GF(2^8) modulo 0x11D is 1. The element is bit-packed with bit i as the coefficient of x^i.
- R2: An input of 0x00 yields an output of 0x00.
- R3: With OUT_REG=1, out_valid equals in_valid from the preceding clock edge.
- R4: With OUT_REG=1, out_inv after a clock edge at which in_valid was 1 is the inverse of the in_elem sampled at that edge.
- R5: With OUT_REG=1, out_inv keeps its value across every edge at which in_valid is 0.
- R6: With OUT_REG=0, out_valid equals in_valid and out_inv is the inverse of in_elem in the same cycle, with no clock edge in between.
- R7: While rst_n is low with OUT_REG=1, out_valid and out_inv are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_elem as a request |
| in_elem | input | 8 | Field element to invert, polynomial basis |
| out_valid | output | 1 | Marks out_inv as a result |
| out_inv | output | 8 | Inverse of the element, 0 for input 0 |

## Verification
A wrong term in any XOR network or multiplier corrupts the result for a subset of inputs. The error shows on out_inv in the same cycle in combinational mode, or one edge later in registered mode. The bench therefore sweeps all 256 inputs and checks each product against a multiplier of its own. A valid flag or hold enable that is misaligned shows within one edge as a mismatch between out_valid and the delayed request, or as a held value that changes.

// File: rtl/gf8_pkg.sv
package gf8_pkg;

   localparam int unsigned GF_W = 8;
   localparam logic [GF_W:0] GF_POLY = 9'h11D;

   typedef logic [GF_W-1:0] gf_elem_t;

   // x^k reduced modulo the field polynomial
   function automatic gf_elem_t basis_pow(input int unsigned k, input logic [GF_W:0] poly);
      gf_elem_t r;
      r = gf_elem_t'(1);
      for (int unsigned s = 0; s < k; s++) begin
         if (r[GF_W-1]) r = {r[GF_W-2:0], 1'b0} ^ poly[GF_W-1:0];
         else           r = {r[GF_W-2:0], 1'b0};
      end
      return r;
   endfunction

   // general product, used by checks only
   function automatic gf_elem_t gf_mul(input gf_elem_t a, input gf_elem_t b,
                                       input logic [GF_W:0] poly);
      gf_elem_t acc;
      acc = '0;
      for (int i = GF_W-1; i >= 0; i--) begin
         if (acc[GF_W-1]) acc = {acc[GF_W-2:0], 1'b0} ^ poly[GF_W-1:0];
         else             acc = {acc[GF_W-2:0], 1'b0};
         if (b[i]) acc = acc ^ a;
      end
      return acc;
   endfunction

endpackage

// File: rtl/gf8_frob.sv
// Linear power stage: out = in^(2^SHIFT), built as a constant XOR matrix.
module gf8_frob #(
   parameter int unsigned   W     = gf8_pkg::GF_W,
   parameter logic [W:0]    POLY  = gf8_pkg::GF_POLY,
   parameter int unsigned   SHIFT = 1
) (
   input  logic [W-1:0] in_v,
   output logic [W-1:0] out_v
);
   localparam int unsigned STEP = 1 << SHIFT;

   if (W != gf8_pkg::GF_W) begin : g_bad_w
      $error("gf8_frob: W must equal %0d", gf8_pkg::GF_W);
   end
   if (SHIFT < 1 || SHIFT > 3) begin : g_bad_shift
      $error("gf8_frob: SHIFT out of range");
   end

   logic [W-1:0] term [W];

   for (genvar gi = 0; gi < W; gi++) begin : g_col
      localparam logic [W-1:0] COL = gf8_pkg::basis_pow(gi * STEP, POLY);
      assign term[gi] = {W{in_v[gi]}} & COL;
   end

   always_comb begin
      out_v = '0;
      for (int i = 0; i < W; i++) out_v = out_v ^ term[i];
   end
endmodule

// File: rtl/gf8_mult.sv
// General GF(2^W) multiplier, MSB-first shift and reduce.
module gf8_mult #(
   parameter int unsigned W    = gf8_pkg::GF_W,
   parameter logic [W:0]  POLY = gf8_pkg::GF_POLY
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] prod
);
   if (!POLY[W]) begin : g_bad_poly
      $error("gf8_mult: POLY must have degree W");
   end

   always_comb begin
      logic [W-1:0] acc;
      logic         top;
      acc = '0;
      for (int i = W-1; i >= 0; i--) begin
         top = acc[W-1];
         acc = {acc[W-2:0], 1'b0};
         if (top)     acc = acc ^ POLY[W-1:0];
         if (op_b[i]) acc = acc ^ op_a;
      end
      prod = acc;
   end
endmodule

// File: rtl/gf8_inv_chain.sv
// a^254 = a^224 * a^24 * a^6, all partial powers from one cube.
module gf8_inv_chain #(
   parameter int unsigned W    = gf8_pkg::GF_W,
   parameter logic [W:0]  POLY = gf8_pkg::GF_POLY
) (
   input  logic [W-1:0] elem,
   output logic [W-1:0] inv
);
   logic [W-1:0] p2, p3, p6, p7, p14, p56, p224, p24, p248;

   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(1)) u_sq1  (.in_v(elem), .out_v(p2));
   gf8_mult #(.W(W), .POLY(POLY))            u_cube (.op_a(p2), .op_b(elem), .prod(p3));
   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(1)) u_sq3  (.in_v(p3), .out_v(p6));
   gf8_mult #(.W(W), .POLY(POLY))            u_sev  (.op_a(p6), .op_b(elem), .prod(p7));
   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(1)) u_sq7  (.in_v(p7), .out_v(p14));
   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(2)) u_q14  (.in_v(p14), .out_v(p56));
   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(2)) u_q56  (.in_v(p56), .out_v(p224));
   gf8_frob #(.W(W), .POLY(POLY), .SHIFT(2)) u_q6   (.in_v(p6), .out_v(p24));
   gf8_mult #(.W(W), .POLY(POLY))            u_m248 (.op_a(p224), .op_b(p24), .prod(p248));
   gf8_mult #(.W(W), .POLY(POLY))            u_m254 (.op_a(p248), .op_b(p6), .prod(inv));
endmodule

// File: rtl/gf8_inverter.sv
module gf8_inverter #(
   parameter int unsigned W       = gf8_pkg::GF_W,
   parameter logic [W:0]  POLY    = gf8_pkg::GF_POLY,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_elem,
   output logic         out_valid,
   output logic [W-1:0] out_inv
);
   if (W != gf8_pkg::GF_W) begin : g_bad_w
      $error("gf8_inverter: power chain is fixed to W=%0d", gf8_pkg::GF_W);
   end

   logic [W-1:0] comb_inv;

   gf8_inv_chain #(.W(W), .POLY(POLY)) u_chain (.elem(in_elem), .inv(comb_inv));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_inv   <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) out_inv <= comb_inv;
         end
      end

      assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> out_valid == $past(in_valid));

      assert_reg_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_elem != '0) |=>
            gf8_pkg::gf_mul(out_inv, $past(in_elem), POLY) == W'(1));

      assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(out_inv));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_inv   = comb_inv;
   end

   assert_unit_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_elem != '0) |-> gf8_pkg::gf_mul(in_elem, comb_inv, POLY) == W'(1));

   assert_zero_maps_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_elem == '0) |-> comb_inv == '0);
endmodule

// File: tb/test_gf8_inverter.sv
`timescale 1ns/1ps
module test_gf8_inverter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_elem = 8'h00;
   logic       out_valid, c_valid;
   logic [7:0] out_inv, c_inv;
   int         n_checks = 0;
   int         n_errors = 0;
   logic [7:0] held = 8'h00;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   gf8_inverter #(.OUT_REG(1'b1)) i_gf8_inverter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_elem(in_elem),
      .out_valid(out_valid), .out_inv(out_inv));

   gf8_inverter #(.OUT_REG(1'b0)) i_gf8_inverter_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_elem(in_elem),
      .out_valid(c_valid), .out_inv(c_inv));

   // reference product: add-and-double with reduction by 0x11D
   function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
      logic [7:0] r = 8'h00;
      logic [7:0] a = x;
      for (int k = 0; k < 8; k++) begin
         if (y[k]) r ^= a;
         a = a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] ref_inv(input logic [7:0] x);
      if (x == 8'h00) return 8'h00;
      for (int b = 1; b < 256; b++)
         if (ref_mul(x, 8'(b)) == 8'h01) return 8'(b);
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [7:0] e);
      logic [7:0] ei;
      @(negedge clk);
      in_valid = v;
      in_elem  = e;
      ei = ref_inv(e);
      #1;
      check("R6 valid", {7'b0, c_valid}, {7'b0, v});
      check("R6 inverse", c_inv, ei);
      if (e == 8'h00) check("R2", c_inv, 8'h00);
      else            check("R1", ref_mul(e, c_inv), 8'h01);
      @(posedge clk);
      #1;
      check("R3", {7'b0, out_valid}, {7'b0, v});
      if (v) begin
         held = ei;
         check("R4", out_inv, ei);
      end else begin
         check("R5", out_inv, held);
      end
   endtask

   initial begin
      #2000000;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      in_elem = 8'hA5;
      in_valid = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R7 valid", {7'b0, out_valid}, 8'h00);
      check("R7 data", out_inv, 8'h00);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
      // directed corners
      step(1'b1, 8'h00);   // R2
      step(1'b1, 8'h01);   // R1 identity
      step(1'b1, 8'h02);
      step(1'b0, 8'h7F);   // R5 hold
      step(1'b1, 8'hFF);
      // exhaustive sweep
      for (int a = 0; a < 256; a++) step(1'b1, 8'(a));
      // random traffic with idle gaps
      for (int r = 0; r < 400; r++) step(1'($urandom % 3 != 0), 8'($urandom));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule